// File: doc/BRIEF.md
# Hotplug slot status register bank

This block keeps the hotplug bookkeeping for several downstream buses of up to 32 slots each. Hardware reports a newly inserted card with a per-slot plug pulse and a removal request with a per-slot unplug pulse. The bank latches each one into a per-bus "arrived" or "leaving" bitmap and raises a one-cycle interrupt pulse. Firmware then walks the buses through a small 32-bit register window. It writes a bus number into the select register and reads the bitmaps for that bus. It acknowledges a removal by writing a slot mask to the eject register. The bank reduces that mask to its lowest set slot and clears that slot's pending bits. It then emits an eject strobe that carries the bus and slot numbers to the logic that tears the device down.

A bank-reset request drains every outstanding removal on every bus, one slot per cycle, lowest bus and lowest slot first. It then rebuilds each bus's removable bitmap from the hardware non-removable mask. The same rebuild runs after a hard reset. While either sequence runs, `busy` is high and register accesses are held off through `reg_ready`. A compile-time legacy option keeps the arrived bitmap from clearing on read and pins the select register to bus 0.

The control state machine has three states. `ST_RMV_LOAD` rebuilds the removable bitmaps and is entered at hard reset. `ST_IDLE` serves register accesses. `ST_DRAIN` ejects pending removals. The transitions are:
- IDLE→DRAIN on `bank_reset`, with the bus cursor set to 0.
- DRAIN→DRAIN while the cursor bus still has a pending removal. One slot is ejected per cycle.
- DRAIN→DRAIN with the cursor advanced when the cursor bus is empty and is not the last bus.
- DRAIN→RMV_LOAD when the last bus is empty.
- RMV_LOAD→IDLE unconditionally.

Top module: `hp_slot_bank`

## Requirements
- R1: Register offsets, all 32-bit words:
  - Arrived bitmap at 0x00.
  - Leaving bitmap at 0x04.
  - Eject/feature word at 0x08, which always reads 0.
  - Removable bitmap at 0x0C.
  - Bus select at 0x10.

  Any other address reads 0, and writes to it have no effect.
- R2: After hard reset the select register reads 0 and the arrived and leaving bitmaps of every bus read 0. `busy` stays high until the first clock edge after reset is released, and the removable bitmap of bus b then reads the inverse of bit field b (bits b*32..b*32+31) of `nonrem_mask`.
- R3: In normal mode, a read of offset 0x00 returns the selected bus's arrived bitmap and clears it. In legacy mode the same read leaves the bitmap unchanged.
- R4: When the select register holds a value of NUM_BUS or more, every read returns 0 (the select offset included) and eject writes do nothing.
- R5: A pulse on bit b*32+s of `plug_evt` sets slot s in bus b's arrived bitmap. The same bit of `unplug_evt` sets slot s in bus b's leaving bitmap. Either pulse makes `evt_irq` high in the following cycle.
- R6: A write to 0x08 with a nonzero value acts on the selected bus and ejects only the slot given by the lowest set bit of the value. It clears that slot in both the leaving and arrived bitmaps. In the following cycle it pulses `eject_stb`, with `eject_bus` and `eject_slot` naming the slot. A zero value does nothing.
- R7: In legacy mode any write to 0x10 leaves the select register at 0. In normal mode the write loads the written value.
- R8: A plug or unplug pulse that hits the same bit in the same cycle as a read-clear or an eject wins, and the bit ends up set.
- R9: A `bank_reset` pulse in idle ejects every pending leaving slot, one strobe per cycle, in ascending bus order and ascending slot order within a bus. It clears each drained slot's arrived bit as well. It then reloads every removable bitmap from the current `nonrem_mask`. `busy` stays high for exactly pending + NUM_BUS + 1 cycles.
- R10: While `busy` is high, `reg_ready` is low and no register access is accepted.
- R11: Read data appears on `reg_rdata` with `reg_rvalid` high in the cycle after the read is accepted (`reg_req` and `reg_ready` high at a clock edge with `reg_we` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset in the register window |
| reg_wdata | input | 32 | Write data |
| reg_ready | output | 1 | Access accepted at this edge when high |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Read data |
| plug_evt | input | NUM_BUS*32 | Per-bus, per-slot insertion pulses |
| unplug_evt | input | NUM_BUS*32 | Per-bus, per-slot removal-request pulses |
| nonrem_mask | input | NUM_BUS*32 | Per-bus, per-slot non-removable flags |
| bank_reset | input | 1 | Request a drain and a removable-bitmap reload |
| evt_irq | output | 1 | One-cycle event pulse |
| eject_stb | output | 1 | One-cycle eject strobe |
| eject_bus | output | clog2(NUM_BUS) | Bus of the ejected slot |
| eject_slot | output | 5 | Slot of the ejected slot |
| busy | output | 1 | Reset rebuild or drain in progress |

## Verification
A wrong bitmap bit is invisible until firmware selects that bus and reads the word. It then appears in the very next read. A stale arrived bit also shows as a second nonzero read of offset 0x00. A lost leaving bit is seen at the next bank reset, where the strobe sequence and the exact length of `busy` expose any missing or extra pending slot. A wrong select value shows at once, because out-of-range reads become 0 and an eject lands on the wrong bus, which the `eject_bus` value reveals in the cycle after the write.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int DATA_W = 32;
    localparam int SLOT_W = 32;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_UP    = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DOWN  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_EJECT = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_RMV   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_SEL   = 5'h10;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_DRAIN    = 2'd1,
        ST_RMV_LOAD = 2'd2
    } hp_state_e;
endpackage

// File: rtl/hp_lowbit.sv
module hp_lowbit #(
    parameter int W = 32,
    localparam int IW = (W > 1) ? $clog2(W) : 1
)(
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  onehot
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
        onehot = vec & (~vec + 1'b1);
    end
endmodule

// File: rtl/hp_bus_status.sv
module hp_bus_status #(
    parameter int W = 32
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] plug,
    input  logic [W-1:0] unplug,
    input  logic [W-1:0] nonrem,
    input  logic         clr_up_all,
    input  logic [W-1:0] eject_mask,
    input  logic         load_rmv,
    output logic [W-1:0] up,
    output logic [W-1:0] down,
    output logic [W-1:0] rmv
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up   <= '0;
            down <= '0;
            rmv  <= '1;
        end else begin
            // clears first, new events OR-ed afterwards so they survive
            up   <= (up & ~(eject_mask | {W{clr_up_all}})) | plug;
            down <= (down & ~eject_mask) | unplug;
            if (load_rmv) begin
                rmv <= ~nonrem;
            end
        end
    end
endmodule

// File: rtl/hp_ctrl_fsm.sv
module hp_ctrl_fsm
    import hp_pkg::*;
#(
    parameter int NUM_BUS = 4,
    localparam int BW = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drain_req,
    input  logic          cur_pending,
    output logic [BW-1:0] cursor,
    output logic          drain_eject,
    output logic          load_rmv,
    output logic          busy
);
    hp_state_e     state;
    hp_state_e     state_nxt;
    logic [BW-1:0] cursor_nxt;

    always_comb begin
        state_nxt  = state;
        cursor_nxt = cursor;
        unique case (state)
            ST_IDLE: begin
                if (drain_req) begin
                    state_nxt  = ST_DRAIN;
                    cursor_nxt = '0;
                end
            end
            ST_DRAIN: begin
                if (!cur_pending) begin
                    if (cursor == BW'(NUM_BUS - 1)) begin
                        state_nxt = ST_RMV_LOAD;
                    end else begin
                        cursor_nxt = cursor + 1'b1;
                    end
                end
            end
            ST_RMV_LOAD: begin
                state_nxt = ST_IDLE;
            end
            default: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_RMV_LOAD;
            cursor <= '0;
        end else begin
            state  <= state_nxt;
            cursor <= cursor_nxt;
        end
    end

    always_comb begin
        busy        = (state != ST_IDLE);
        drain_eject = (state == ST_DRAIN) && cur_pending;
        load_rmv    = (state == ST_RMV_LOAD);
    end
endmodule

// File: rtl/hp_slot_bank.sv
module hp_slot_bank
    import hp_pkg::*;
#(
    parameter int NUM_BUS = 4,
    parameter bit LEGACY  = 1'b0,
    localparam int BW   = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
    localparam int SW   = $clog2(SLOT_W),
    localparam int FLAT = NUM_BUS * SLOT_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              reg_ready,
    output logic              reg_rvalid,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [FLAT-1:0]   plug_evt,
    input  logic [FLAT-1:0]   unplug_evt,
    input  logic [FLAT-1:0]   nonrem_mask,
    input  logic              bank_reset,
    output logic              evt_irq,
    output logic              eject_stb,
    output logic [BW-1:0]     eject_bus,
    output logic [SW-1:0]     eject_slot,
    output logic              busy
);
    logic [DATA_W-1:0] sel_q;
    logic              sel_ok;
    logic [BW-1:0]     sel_idx;
    logic              acc_rd;
    logic              acc_wr;
    logic              rd_clear;

    logic [SLOT_W-1:0] up_arr   [NUM_BUS];
    logic [SLOT_W-1:0] down_arr [NUM_BUS];
    logic [SLOT_W-1:0] rmv_arr  [NUM_BUS];
    logic [FLAT-1:0]   down_flat;
    logic [SLOT_W-1:0] up_sel;
    logic [SLOT_W-1:0] down_sel;
    logic [SLOT_W-1:0] rmv_sel;
    logic [SLOT_W-1:0] cur_down;
    logic [DATA_W-1:0] rd_mux;

    logic [BW-1:0]     cursor;
    logic              drain_eject;
    logic              load_rmv;

    logic [SLOT_W-1:0] ej_vec;
    logic [SLOT_W-1:0] ej_onehot;
    logic              ej_found;
    logic [SW-1:0]     ej_idx;
    logic              wr_eject;
    logic              ej_go;
    logic [BW-1:0]     ej_bus;

    assign sel_ok    = (sel_q < DATA_W'(NUM_BUS));
    assign sel_idx   = sel_q[BW-1:0];
    assign reg_ready = ~busy;
    assign acc_rd    = reg_req & reg_ready & ~reg_we;
    assign acc_wr    = reg_req & reg_ready & reg_we;
    assign rd_clear  = !LEGACY && acc_rd && (reg_addr == OFS_UP) && sel_ok;
    assign cur_down  = down_arr[cursor];

    hp_ctrl_fsm #(.NUM_BUS(NUM_BUS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .drain_req   (bank_reset),
        .cur_pending (cur_down != '0),
        .cursor      (cursor),
        .drain_eject (drain_eject),
        .load_rmv    (load_rmv),
        .busy        (busy)
    );

    // one priority encoder shared by firmware ejects and reset draining
    assign ej_vec = busy ? cur_down : reg_wdata;

    hp_lowbit #(.W(SLOT_W)) u_lowbit (
        .vec    (ej_vec),
        .found  (ej_found),
        .idx    (ej_idx),
        .onehot (ej_onehot)
    );

    assign wr_eject = acc_wr && (reg_addr == OFS_EJECT) && sel_ok && ej_found;
    assign ej_go    = drain_eject | wr_eject;
    assign ej_bus   = drain_eject ? cursor : sel_idx;

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        hp_bus_status #(.W(SLOT_W)) u_bus (
            .clk        (clk),
            .rst_n      (rst_n),
            .plug       (plug_evt[b*SLOT_W +: SLOT_W]),
            .unplug     (unplug_evt[b*SLOT_W +: SLOT_W]),
            .nonrem     (nonrem_mask[b*SLOT_W +: SLOT_W]),
            .clr_up_all (rd_clear && (sel_idx == BW'(b))),
            .eject_mask ((ej_go && (ej_bus == BW'(b))) ? ej_onehot : '0),
            .load_rmv   (load_rmv),
            .up         (up_arr[b]),
            .down       (down_arr[b]),
            .rmv        (rmv_arr[b])
        );
        assign down_flat[b*SLOT_W +: SLOT_W] = down_arr[b];
    end

    always_comb begin
        if (sel_ok) begin
            up_sel   = up_arr[sel_idx];
            down_sel = down_arr[sel_idx];
            rmv_sel  = rmv_arr[sel_idx];
        end else begin
            up_sel   = '0;
            down_sel = '0;
            rmv_sel  = '0;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (sel_ok) begin
            case (reg_addr)
                OFS_UP:   rd_mux = up_sel;
                OFS_DOWN: rd_mux = down_sel;
                OFS_RMV:  rd_mux = rmv_sel;
                OFS_SEL:  rd_mux = sel_q;
                default:  rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q      <= '0;
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
            evt_irq    <= 1'b0;
            eject_stb  <= 1'b0;
            eject_bus  <= '0;
            eject_slot <= '0;
        end else begin
            if (acc_wr && (reg_addr == OFS_SEL)) begin
                sel_q <= LEGACY ? '0 : reg_wdata;
            end
            reg_rvalid <= acc_rd;
            if (acc_rd) begin
                reg_rdata <= rd_mux;
            end
            evt_irq    <= (|plug_evt) | (|unplug_evt);
            eject_stb  <= ej_go;
            eject_bus  <= ej_bus;
            eject_slot <= ej_idx;
        end
    end
endmodule

// File: rtl/hp_slot_bank_chk.sv
module hp_slot_bank_chk
    import hp_pkg::*;
#(
    parameter int NUM_BUS = 4,
    parameter bit LEGACY  = 1'b0,
    localparam int BW   = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
    localparam int SW   = $clog2(SLOT_W),
    localparam int FLAT = NUM_BUS * SLOT_W
)(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_req,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_ready,
    input logic              reg_rvalid,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [FLAT-1:0]   plug_evt,
    input logic [FLAT-1:0]   unplug_evt,
    input logic              evt_irq,
    input logic              eject_stb,
    input logic [BW-1:0]     eject_bus,
    input logic [SW-1:0]     eject_slot,
    input logic              busy,
    input logic [DATA_W-1:0] sel_q,
    input logic [SLOT_W-1:0] up_sel,
    input logic [FLAT-1:0]   down_flat
);
    logic            rd_acc;
    logic [FLAT-1:0] unplug_q;
    logic [BW+SW-1:0] ej_pos;

    assign rd_acc = reg_req && reg_ready && !reg_we;
    assign ej_pos = {eject_bus, eject_slot};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) unplug_q <= '0;
        else        unplug_q <= unplug_evt;
    end

    a_r5_irq_after_event: assert property (@(posedge clk) disable iff (!rst_n)
        ((|plug_evt) || (|unplug_evt)) |=> evt_irq);

    a_r10_stall_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !reg_ready);

    a_r11_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> reg_rvalid);

    a_r4_badsel_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && (sel_q >= DATA_W'(NUM_BUS))) |=> (reg_rdata == '0));

    a_r6_eject_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        eject_stb |-> (!down_flat[ej_pos] || unplug_q[ej_pos]));

    if (!LEGACY) begin : g_norm
        a_r3_up_cleared_by_read: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_acc && (reg_addr == OFS_UP) && (plug_evt == '0)) |=> (up_sel == '0));
    end else begin : g_leg
        a_r3_legacy_up_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_acc && (reg_addr == OFS_UP) && (plug_evt == '0)) |=> (up_sel == $past(up_sel)));
        a_r7_legacy_sel_zero: assert property (@(posedge clk) disable iff (!rst_n)
            sel_q == '0);
    end
endmodule

bind hp_slot_bank hp_slot_bank_chk #(.NUM_BUS(NUM_BUS), .LEGACY(LEGACY)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_req    (reg_req),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_ready  (reg_ready),
    .reg_rvalid (reg_rvalid),
    .reg_rdata  (reg_rdata),
    .plug_evt   (plug_evt),
    .unplug_evt (unplug_evt),
    .evt_irq    (evt_irq),
    .eject_stb  (eject_stb),
    .eject_bus  (eject_bus),
    .eject_slot (eject_slot),
    .busy       (busy),
    .sel_q      (sel_q),
    .up_sel     (up_sel),
    .down_flat  (down_flat)
);

// File: tb/hp_slot_bank_test.sv
`timescale 1ns/1ps
module hp_slot_bank_test;
    localparam int NB = 4;
    localparam int FL = NB * 32;
    localparam logic [4:0] A_UP = 5'h00, A_DN = 5'h04, A_EJ = 5'h08, A_RM = 5'h0C, A_SEL = 5'h10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_req = 1'b0, reg_we = 1'b0, bank_reset = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [FL-1:0] plug_evt = '0, unplug_evt = '0, nonrem_mask = '0;

    logic        ready_o [2];
    logic        rvalid_o [2];
    logic [31:0] rdata_o [2];
    logic        irq_o [2];
    logic        stb_o [2];
    logic [1:0]  ebus_o [2];
    logic [4:0]  eslot_o [2];
    logic        busy_o [2];

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] m_up   [2][NB];
    logic [31:0] m_down [2][NB];
    logic [31:0] m_rmv  [NB];
    logic [31:0] m_sel  [2];

    always #2 clk = ~clk;

    hp_slot_bank #(.NUM_BUS(NB), .LEGACY(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ready(ready_o[0]), .reg_rvalid(rvalid_o[0]), .reg_rdata(rdata_o[0]),
        .plug_evt(plug_evt), .unplug_evt(unplug_evt), .nonrem_mask(nonrem_mask), .bank_reset(bank_reset),
        .evt_irq(irq_o[0]), .eject_stb(stb_o[0]), .eject_bus(ebus_o[0]), .eject_slot(eslot_o[0]), .busy(busy_o[0]));

    hp_slot_bank #(.NUM_BUS(NB), .LEGACY(1'b1)) uut_leg (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ready(ready_o[1]), .reg_rvalid(rvalid_o[1]), .reg_rdata(rdata_o[1]),
        .plug_evt(plug_evt), .unplug_evt(unplug_evt), .nonrem_mask(nonrem_mask), .bank_reset(bank_reset),
        .evt_irq(irq_o[1]), .eject_stb(stb_o[1]), .eject_bus(ebus_o[1]), .eject_slot(eslot_o[1]), .busy(busy_o[1]));

    task automatic chk(input string tag, input int d, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s dut%0d actual=%h expected=%h", tag, d, act, exp);
        end
    endtask

    function automatic int lowest(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] nr_pat(input int b, input int sh);
        return 32'h0000_0003 << (b * 8 + sh);
    endfunction

    function automatic logic [31:0] exp_read(input int d, input logic [4:0] a);
        if (m_sel[d] >= NB) return 32'h0;
        case (a)
            A_UP:    return m_up[d][int'(m_sel[d])];
            A_DN:    return m_down[d][int'(m_sel[d])];
            A_RM:    return m_rmv[int'(m_sel[d])];
            A_SEL:   return m_sel[d];
            default: return 32'h0;
        endcase
    endfunction

    task automatic rd(input logic [4:0] a, input string tag, input int cb = -1, input int cs = 0);
        logic [31:0] e [2];
        for (int d = 0; d < 2; d++) e[d] = exp_read(d, a);
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
        if (cb >= 0) plug_evt[cb*32+cs] = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_req = 1'b0; plug_evt = '0;
        for (int d = 0; d < 2; d++) begin
            chk({"R11 rvalid ", tag}, d, 32'(rvalid_o[d]), 32'h1);
            chk(tag, d, rdata_o[d], e[d]);
        end
        if (a == A_UP && m_sel[0] < NB) m_up[0][int'(m_sel[0])] = 32'h0;
        if (cb >= 0) for (int d = 0; d < 2; d++) m_up[d][cb][cs] = 1'b1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v, input string tag,
                      input int ub = -1, input int us = 0);
        bit es [2];
        int eb [2];
        int esl [2];
        for (int d = 0; d < 2; d++) begin
            es[d] = 1'b0; eb[d] = 0; esl[d] = 0;
            if (a == A_EJ && m_sel[d] < NB && v != 0) begin
                es[d] = 1'b1; eb[d] = int'(m_sel[d]); esl[d] = lowest(v);
            end
        end
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        if (ub >= 0) unplug_evt[ub*32+us] = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0; unplug_evt = '0;
        if (a == A_EJ) begin
            for (int d = 0; d < 2; d++) begin
                chk({"R6 strobe ", tag}, d, 32'(stb_o[d]), 32'(es[d]));
                if (es[d]) begin
                    chk({"R6 bus ", tag}, d, 32'(ebus_o[d]), 32'(eb[d]));
                    chk({"R6 slot ", tag}, d, 32'(eslot_o[d]), 32'(esl[d]));
                end
            end
        end
        for (int d = 0; d < 2; d++) begin
            if (es[d]) begin
                m_down[d][eb[d]][esl[d]] = 1'b0;
                m_up[d][eb[d]][esl[d]] = 1'b0;
            end
            if (a == A_SEL) m_sel[d] = (d == 1) ? 32'h0 : v;
            if (ub >= 0) m_down[d][ub][us] = 1'b1;
        end
    endtask

    task automatic ev(input bit is_plug, input int b, input int s);
        if (is_plug) plug_evt[b*32+s] = 1'b1;
        else         unplug_evt[b*32+s] = 1'b1;
        @(posedge clk); @(negedge clk);
        plug_evt = '0; unplug_evt = '0;
        for (int d = 0; d < 2; d++) begin
            chk("R5 evt_irq", d, 32'(irq_o[d]), 32'h1);
            if (is_plug) m_up[d][b][s] = 1'b1;
            else         m_down[d][b][s] = 1'b1;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        int xb [128];
        int xs [128];
        int np;
        int bcnt [2];
        int scnt [2];
        for (int d = 0; d < 2; d++) begin
            m_sel[d] = 0;
            for (int b = 0; b < NB; b++) begin m_up[d][b] = 0; m_down[d][b] = 0; end
        end
        for (int b = 0; b < NB; b++) begin
            nonrem_mask[b*32 +: 32] = nr_pat(b, 0);
            m_rmv[b] = ~nr_pat(b, 0);
        end

        // R2: hard reset
        repeat (3) @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            chk("R2 busy in reset", d, 32'(busy_o[d]), 32'h1);
            chk("R10 ready low in reset", d, 32'(ready_o[d]), 32'h0);
            chk("R5 irq idle", d, 32'(irq_o[d]), 32'h0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int d = 0; d < 2; d++) chk("R2 busy after rebuild", d, 32'(busy_o[d]), 32'h0);
        rd(A_SEL, "R2 select reset");
        rd(A_RM,  "R2 removable bus0");
        rd(A_UP,  "R2 up reset");
        rd(A_DN,  "R2 down reset");

        // R1: feature word and unused / misaligned offsets
        rd(A_EJ,  "R1 feature word");
        rd(5'h14, "R1 unused offset");
        rd(5'h02, "R1 misaligned offset");
        wr(5'h18, 32'h3, "R1 unused write");
        rd(A_SEL, "R1 select after unused write");

        // R3 R5 R7: sweep buses
        for (int b = 0; b < NB; b++) begin
            wr(A_SEL, 32'(b), "R7 select write");
            rd(A_SEL, "R7 select readback");
            for (int k = 0; k < 3; k++) ev(1'b1, b, (b * 11 + k * 13) % 32);
            rd(A_UP, "R3 up first read");
            rd(A_UP, "R3 up second read");
            ev(1'b0, b, (b * 5 + 7) % 32);
            rd(A_DN, "R5 down read");
            rd(A_RM, "R2 removable per bus");
        end

        // R6: eject lowest bit on bus 0
        wr(A_SEL, 32'h0, "R7 select bus0");
        ev(1'b0, 0, 4);
        ev(1'b0, 0, 6);
        ev(1'b1, 0, 4);
        wr(A_EJ, 32'h0000_0050, "R6 multi-bit eject");
        rd(A_DN, "R6 down after eject");
        rd(A_UP, "R6 up after eject");
        wr(A_EJ, 32'h0, "R6 zero eject");
        rd(A_DN, "R6 down after zero eject");

        // R4: out-of-range select
        wr(A_SEL, 32'h9, "R4 select out of range");
        rd(A_UP,  "R4 up bad sel");
        rd(A_DN,  "R4 down bad sel");
        rd(A_RM,  "R4 rmv bad sel");
        rd(A_SEL, "R4 sel bad sel");
        wr(A_EJ, 32'h8000_0000, "R4 eject bad sel");

        // R8: collisions
        wr(A_SEL, 32'h2, "R7 select bus2");
        rd(A_UP, "R8 read-clear with plug", 2, 20);
        rd(A_UP, "R8 plug survived read-clear");
        wr(A_SEL, 32'h1, "R7 select bus1");
        ev(1'b0, 1, 3);
        wr(A_EJ, 32'h0000_0008, "R8 eject with unplug", 1, 3);
        rd(A_DN, "R8 unplug survived eject");

        // R9 R10: drain
        ev(1'b0, 1, 9);
        ev(1'b0, 3, 0);
        ev(1'b0, 3, 30);
        np = 0;
        for (int b = 0; b < NB; b++)
            for (int s = 0; s < 32; s++)
                if (m_down[0][b][s]) begin xb[np] = b; xs[np] = s; np++; end
        for (int b = 0; b < NB; b++) nonrem_mask[b*32 +: 32] = nr_pat(b, 4);
        bank_reset = 1'b1;
        @(posedge clk); @(negedge clk);
        bank_reset = 1'b0;
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = A_SEL;
        bcnt[0] = 0; bcnt[1] = 0; scnt[0] = 0; scnt[1] = 0;
        for (int c = 0; c < 300 && (busy_o[0] || busy_o[1]); c++) begin
            for (int d = 0; d < 2; d++) begin
                if (busy_o[d]) begin
                    bcnt[d]++;
                    chk("R10 ready low while busy", d, 32'(ready_o[d]), 32'h0);
                    chk("R10 no read accepted", d, 32'(rvalid_o[d]), 32'h0);
                end
                if (stb_o[d]) begin
                    if (scnt[d] < np) begin
                        chk("R9 drain bus", d, 32'(ebus_o[d]), 32'(xb[scnt[d]]));
                        chk("R9 drain slot", d, 32'(eslot_o[d]), 32'(xs[scnt[d]]));
                    end
                    scnt[d]++;
                end
            end
            @(negedge clk);
        end
        reg_req = 1'b0;
        for (int d = 0; d < 2; d++) begin
            chk("R9 strobe count", d, 32'(scnt[d]), 32'(np));
            chk("R9 busy length", d, 32'(bcnt[d]), 32'(np + NB + 1));
        end
        for (int k = 0; k < np; k++)
            for (int d = 0; d < 2; d++) begin
                m_down[d][xb[k]][xs[k]] = 1'b0;
                m_up[d][xb[k]][xs[k]] = 1'b0;
            end
        for (int b = 0; b < NB; b++) m_rmv[b] = ~nr_pat(b, 4);
        for (int b = 0; b < NB; b++) begin
            wr(A_SEL, 32'(b), "R7 select after drain");
            rd(A_DN, "R9 down drained");
            rd(A_RM, "R9 removable reloaded");
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule